// File: doc/BRIEF.md
# DMA Channel Register File

This block is the host-facing register set of a four-channel DMA controller whose registers are all eight bits wide. Each channel has a 16-bit transfer address and a 16-bit transfer count. Each of these is held twice: a base copy and a current copy. A single byte-pointer bit is shared by every 16-bit register and decides whether the next 8-bit access reaches the low half or the high half. The same bit is used for reads and for writes. The control offsets cover the following:

- command on write, status on read
- software request
- single-channel mask
- per-channel mode
- pointer reset
- master clear on write, temporary value on read
- clear of all masks
- load of all masks

A transfer engine outside this block steps the current address and count of one channel at a time. Through the same port it learns the channel's current address and whether the next step is the last one. The count holds one less than the number of transfers still to make.

The parameter `STRIDE` sets the offset spacing. With the value 1, registers sit at consecutive offsets. With the value 2, every offset is doubled, so a second copy can be placed on even offsets only.

Read data is registered. A read strobe at a clock edge makes the selected value appear on `host_rdata` after that edge, and the value stays there until the next read.

Top module: `xcr_regs`

## Requirements
- R1: After reset, all four mask bits read 1, the command output is 0x00, status reads 0x00 and the byte pointer selects the low byte.
- R2: Channel n's address sits at index 2n and its count at index 2n+1. Each access to any of these eight indices, read or write, goes to the byte chosen by one shared pointer: low first, then high. The pointer toggles after the access. A write loads base and current together, and a read returns the current value.
- R3: Any write to index 0x0C returns the shared pointer to the low byte, whatever the data.
- R4: A write to index 0x08 loads the command output. A write to index 0x0D sets all mask bits and clears command, request bits, terminal-count flags and the pointer. A read of 0x0D returns 0x00.
- R5: A write to index 0x0A sets the mask bit of channel data[1:0] to data[2] (1 masks). The other mask bits do not change, and mask bits change only on host writes.
- R6: A write to index 0x0E clears all four mask bits. A write to index 0x0F loads them from data[3:0].
- R7: A write to index 0x0B stores data[7:2] as the mode of channel data[1:0]. The field is {kind[1:0], decrement, auto-init, direction[1:0]} and appears on mode_o[6n+5:6n]. Other channels keep their modes.
- R8: An engine step on a channel whose current count is non-zero decrements the count. It moves the current address by +1, or by -1 when the mode's decrement bit is set. Base values do not change.
- R9: A step with current count 0 is the terminal count and sets status bit n. Without auto-init, the count wraps to 0xFFFF and the address moves on. With auto-init, both current values reload from base. A loaded count of N therefore gives N+1 steps, and eng_last is 1 while the current count is 0. Terminal-count flags are set only by steps.
- R10: A status read (index 0x08) returns {pending[3:0], tc[3:0]}. Pending is the request bits OR the dreq inputs. The read clears the tc flags it returned.
- R11: A write to index 0x09 sets the request bit of channel data[1:0] to data[2].
- R12: With STRIDE=2, the register at index k sits at offset 2k, and writes to odd offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_off | input | 4 + log2(STRIDE) | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access; ignored when host_wr is high |
| host_rdata | output | 8 | Registered read data |
| dreq | input | 4 | Hardware request lines, reported in status |
| eng_step | input | 1 | Engine advances the current address and count of eng_chan |
| eng_chan | input | 2 | Channel served by the engine |
| eng_addr | output | 16 | Current address of eng_chan |
| eng_last | output | 1 | Current count of eng_chan is zero |
| cmd_o | output | 8 | Command register |
| mask_o | output | 4 | Channel mask bits |
| mode_o | output | 24 | Per-channel mode fields, channel n in bits 6n+5:6n |

## Verification
The bench aims at the shared byte pointer. It writes a low byte to one channel and then touches a different channel's count, which must land on the high byte. A design with a pointer per register would put it in the low byte. It also resets the pointer in the middle of a pair and after a master clear. A design that ignored either reset would read back swapped bytes.

Count zero is driven on three channels. The cases are a wrap to 0xFFFF, a decrementing address, and an auto-init reload, which would show a wrong address or a missing status flag if the terminal-count path were off by one.

The status clear-on-read is checked by a second read. Odd offsets are checked on the stride-2 copy, where a decoder that dropped the low offset bit would run a master clear.

// File: rtl/xcr_pkg.sv
package xcr_pkg;
    localparam int N_CHAN = 4;
    localparam int CH_W   = 2;
    localparam int WORD_W = 16;
    localparam int IDX_W  = 4;
    localparam int MODE_W = 6;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CHAN,
        OP_CMD,
        OP_REQ,
        OP_MASK1,
        OP_MODE,
        OP_CLRPTR,
        OP_MCLR,
        OP_CLRMASK,
        OP_MASKALL
    } host_op_e;

    typedef struct packed {
        host_op_e          op;
        logic [CH_W-1:0]   chan;
        logic              sel_cnt;
    } host_dec_t;

    typedef struct packed {
        logic [1:0] kind;
        logic       decr;
        logic       autoinit;
        logic [1:0] dir;
    } chan_mode_t;
endpackage

// File: rtl/xcr_decode.sv
module xcr_decode
    import xcr_pkg::*;
#(
    parameter int STRIDE = 1,
    localparam int SHIFT = (STRIDE == 2) ? 1 : 0,
    localparam int OFF_W = IDX_W + SHIFT
) (
    input  logic [OFF_W-1:0] off,
    output host_dec_t        dec
);
    logic             aligned;
    logic [IDX_W-1:0] idx;

    always_comb begin
        aligned = 1'b1;
        if (SHIFT == 1) aligned = ~off[0];
        idx = off[OFF_W-1:SHIFT];
        dec = '0;
        dec.op = OP_NONE;
        if (aligned) begin
            if (!idx[IDX_W-1]) begin
                dec.op      = OP_CHAN;
                dec.chan    = idx[CH_W:1];
                dec.sel_cnt = idx[0];
            end else begin
                case (idx[2:0])
                    3'd0:    dec.op = OP_CMD;
                    3'd1:    dec.op = OP_REQ;
                    3'd2:    dec.op = OP_MASK1;
                    3'd3:    dec.op = OP_MODE;
                    3'd4:    dec.op = OP_CLRPTR;
                    3'd5:    dec.op = OP_MCLR;
                    3'd6:    dec.op = OP_CLRMASK;
                    default: dec.op = OP_MASKALL;
                endcase
            end
        end
    end
endmodule

// File: rtl/xcr_chan.sv
module xcr_chan
    import xcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel_cnt,
    input  logic              hi_byte,
    input  logic [7:0]        wdata,
    input  logic              step,
    input  logic              decr,
    input  logic              autoinit,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_cnt,
    output logic              tc_evt
);
    typedef struct packed {
        logic [WORD_W-1:0] base_addr;
        logic [WORD_W-1:0] cur_addr;
        logic [WORD_W-1:0] base_cnt;
        logic [WORD_W-1:0] cur_cnt;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tc_evt = 1'b0;
        if (step) begin
            st_d.cur_addr = decr ? st_q.cur_addr - 1'b1 : st_q.cur_addr + 1'b1;
            st_d.cur_cnt  = st_q.cur_cnt - 1'b1;
            if (st_q.cur_cnt == '0) begin
                tc_evt = 1'b1;
                if (autoinit) begin
                    st_d.cur_addr = st_q.base_addr;
                    st_d.cur_cnt  = st_q.base_cnt;
                end
            end
        end
        // a host byte write overrides the stepped value of that byte
        if (wr_en) begin
            if (sel_cnt) begin
                if (hi_byte) begin
                    st_d.base_cnt[15:8] = wdata;
                    st_d.cur_cnt[15:8]  = wdata;
                end else begin
                    st_d.base_cnt[7:0]  = wdata;
                    st_d.cur_cnt[7:0]   = wdata;
                end
            end else begin
                if (hi_byte) begin
                    st_d.base_addr[15:8] = wdata;
                    st_d.cur_addr[15:8]  = wdata;
                end else begin
                    st_d.base_addr[7:0]  = wdata;
                    st_d.cur_addr[7:0]   = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_addr = st_q.cur_addr;
    assign cur_cnt  = st_q.cur_cnt;
endmodule

// File: rtl/xcr_regs.sv
module xcr_regs
    import xcr_pkg::*;
#(
    parameter int STRIDE = 1,
    localparam int SHIFT = (STRIDE == 2) ? 1 : 0,
    localparam int OFF_W = IDX_W + SHIFT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [OFF_W-1:0]         host_off,
    input  logic [7:0]               host_wdata,
    input  logic                     host_wr,
    input  logic                     host_rd,
    output logic [7:0]               host_rdata,
    input  logic [N_CHAN-1:0]        dreq,
    input  logic                     eng_step,
    input  logic [CH_W-1:0]          eng_chan,
    output logic [WORD_W-1:0]        eng_addr,
    output logic                     eng_last,
    output logic [7:0]               cmd_o,
    output logic [N_CHAN-1:0]        mask_o,
    output logic [N_CHAN*MODE_W-1:0] mode_o
);
    typedef struct packed {
        logic                          ptr_hi;
        logic [7:0]                    cmd;
        logic [N_CHAN-1:0]             tc;
        logic [N_CHAN-1:0]             req;
        logic [N_CHAN-1:0]             mask;
        chan_mode_t [N_CHAN-1:0]       mode;
        logic [7:0]                    rdata;
    } regs_st_t;

    regs_st_t          st_d, st_q;
    host_dec_t         dec;
    logic              wr_go, rd_go;
    logic [N_CHAN-1:0] tc_evt;
    logic [N_CHAN-1:0] tc_flags;
    logic [WORD_W-1:0] cur_addr [N_CHAN];
    logic [WORD_W-1:0] cur_cnt  [N_CHAN];

    xcr_decode #(.STRIDE(STRIDE)) u_dec (
        .off (host_off),
        .dec (dec)
    );

    assign wr_go = host_wr;
    assign rd_go = host_rd & ~host_wr;

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        xcr_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_go && dec.op == OP_CHAN && dec.chan == CH_W'(c)),
            .sel_cnt  (dec.sel_cnt),
            .hi_byte  (st_q.ptr_hi),
            .wdata    (host_wdata),
            .step     (eng_step && eng_chan == CH_W'(c)),
            .decr     (st_q.mode[c].decr),
            .autoinit (st_q.mode[c].autoinit),
            .cur_addr (cur_addr[c]),
            .cur_cnt  (cur_cnt[c]),
            .tc_evt   (tc_evt[c])
        );
    end

    always_comb begin
        st_d    = st_q;
        st_d.tc = st_q.tc | tc_evt;
        if (wr_go) begin
            case (dec.op)
                OP_CHAN:    st_d.ptr_hi = ~st_q.ptr_hi;
                OP_CMD:     st_d.cmd = host_wdata;
                OP_REQ:     st_d.req[host_wdata[CH_W-1:0]] = host_wdata[2];
                OP_MASK1:   st_d.mask[host_wdata[CH_W-1:0]] = host_wdata[2];
                OP_MODE:    st_d.mode[host_wdata[CH_W-1:0]] = host_wdata[7:2];
                OP_CLRPTR:  st_d.ptr_hi = 1'b0;
                OP_MCLR: begin
                    st_d.mask   = '1;
                    st_d.cmd    = '0;
                    st_d.tc     = '0;
                    st_d.req    = '0;
                    st_d.ptr_hi = 1'b0;
                end
                OP_CLRMASK: st_d.mask = '0;
                OP_MASKALL: st_d.mask = host_wdata[N_CHAN-1:0];
                default: ;
            endcase
        end else if (rd_go) begin
            case (dec.op)
                OP_CHAN: begin
                    if (dec.sel_cnt)
                        st_d.rdata = st_q.ptr_hi ? cur_cnt[dec.chan][15:8]
                                                 : cur_cnt[dec.chan][7:0];
                    else
                        st_d.rdata = st_q.ptr_hi ? cur_addr[dec.chan][15:8]
                                                 : cur_addr[dec.chan][7:0];
                    st_d.ptr_hi = ~st_q.ptr_hi;
                end
                OP_CMD: begin
                    st_d.rdata = {st_q.req | dreq, st_q.tc};
                    st_d.tc    = tc_evt;
                end
                default: st_d.rdata = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.rdata;
    assign cmd_o      = st_q.cmd;
    assign mask_o     = st_q.mask;
    assign mode_o     = st_q.mode;
    assign eng_addr   = cur_addr[eng_chan];
    assign eng_last   = (cur_cnt[eng_chan] == '0);
    assign tc_flags   = st_q.tc;
endmodule

// File: rtl/xcr_regs_chk.sv
module xcr_regs_chk
    import xcr_pkg::*;
#(
    parameter int STRIDE = 1,
    localparam int SHIFT = (STRIDE == 2) ? 1 : 0,
    localparam int OFF_W = IDX_W + SHIFT
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OFF_W-1:0]  host_off,
    input logic              host_wr,
    input logic              host_rd,
    input logic              eng_step,
    input logic [7:0]        cmd_o,
    input logic [N_CHAN-1:0] mask_o,
    input logic [N_CHAN-1:0] tc_q
);
    localparam logic [OFF_W-1:0] K_STAT    = OFF_W'(8 * STRIDE);
    localparam logic [OFF_W-1:0] K_MCLR    = OFF_W'(13 * STRIDE);
    localparam logic [OFF_W-1:0] K_CLRMASK = OFF_W'(14 * STRIDE);

    AST_MCLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_off == K_MCLR |=> mask_o == '1 && cmd_o == 8'h00); // R4

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(cmd_o)); // R4

    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(mask_o)); // R5

    AST_CLRMASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_off == K_CLRMASK |=> mask_o == '0); // R6

    AST_TC_ONLY_BY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_step |=> $countones(tc_q) <= $countones($past(tc_q))); // R9

    AST_STATUS_RDCLR: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !host_wr && host_off == K_STAT && !eng_step |=> tc_q == '0); // R10
endmodule

bind xcr_regs xcr_regs_chk #(.STRIDE(STRIDE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_off (host_off),
    .host_wr  (host_wr),
    .host_rd  (host_rd),
    .eng_step (eng_step),
    .cmd_o    (cmd_o),
    .mask_o   (mask_o),
    .tc_q     (tc_flags)
);

// File: tb/xcr_regs_test.sv
module xcr_regs_test;
    localparam int CLK_T = 10;

    localparam logic [4:0] K_CMD = 5'h08, K_REQ = 5'h09, K_MASK1 = 5'h0A, K_MODE = 5'h0B;
    localparam logic [4:0] K_CLRPTR = 5'h0C, K_MCLR = 5'h0D, K_CLRMASK = 5'h0E, K_MASKALL = 5'h0F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_T/2) clk = ~clk;

    // stride-1 copy
    logic [3:0]  off_n = '0;
    logic [7:0]  wd_n = '0, rdat_n;
    logic        wr_n = 1'b0, rd_n = 1'b0;
    logic [3:0]  dreq = '0;
    logic        step = 1'b0;
    logic [1:0]  ech = '0;
    logic [15:0] eaddr;
    logic        elast;
    logic [7:0]  cmd_n;
    logic [3:0]  mask_n;
    logic [23:0] mode_n;

    // stride-2 copy
    logic [4:0]  off_w = '0;
    logic [7:0]  wd_w = '0, rdat_w;
    logic        wr_w = 1'b0, rd_w = 1'b0;
    logic [15:0] eaddr_w;
    logic        elast_w;
    logic [7:0]  cmd_w;
    logic [3:0]  mask_w;
    logic [23:0] mode_w;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    xcr_regs #(.STRIDE(1)) uut (
        .clk(clk), .rst_n(rst_n), .host_off(off_n), .host_wdata(wd_n),
        .host_wr(wr_n), .host_rd(rd_n), .host_rdata(rdat_n), .dreq(dreq),
        .eng_step(step), .eng_chan(ech), .eng_addr(eaddr), .eng_last(elast),
        .cmd_o(cmd_n), .mask_o(mask_n), .mode_o(mode_n)
    );

    xcr_regs #(.STRIDE(2)) uut_w (
        .clk(clk), .rst_n(rst_n), .host_off(off_w), .host_wdata(wd_w),
        .host_wr(wr_w), .host_rd(rd_w), .host_rdata(rdat_w), .dreq(4'h0),
        .eng_step(1'b0), .eng_chan(2'd0), .eng_addr(eaddr_w), .eng_last(elast_w),
        .cmd_o(cmd_w), .mask_o(mask_w), .mode_o(mode_w)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwr(input bit wide, input logic [4:0] off, input logic [7:0] d);
        @(negedge clk);
        if (wide) begin off_w = off; wd_w = d; wr_w = 1'b1; end
        else      begin off_n = off[3:0]; wd_n = d; wr_n = 1'b1; end
        @(negedge clk);
        wr_n = 1'b0;
        wr_w = 1'b0;
    endtask

    task automatic hrd(input bit wide, input logic [4:0] off, output logic [7:0] d);
        @(negedge clk);
        if (wide) begin off_w = off; rd_w = 1'b1; end
        else      begin off_n = off[3:0]; rd_n = 1'b1; end
        @(negedge clk);
        rd_n = 1'b0;
        rd_w = 1'b0;
        d = wide ? rdat_w : rdat_n;
    endtask

    task automatic wr16(input logic [4:0] off, input logic [15:0] v);
        hwr(0, off, v[7:0]);
        hwr(0, off, v[15:8]);
    endtask

    task automatic rd16(input logic [4:0] off, output logic [15:0] v);
        logic [7:0] lo, hi;
        hrd(0, off, lo);
        hrd(0, off, hi);
        v = {hi, lo};
    endtask

    task automatic do_step(input logic [1:0] c);
        @(negedge clk);
        ech = c;
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic peek(input logic [1:0] c);
        @(negedge clk);
        ech = c;
        #1;
    endtask

    task automatic t_reset;
        logic [7:0] s;
        chk("R1 mask after reset", mask_n, 4'hF);
        chk("R1 cmd after reset", cmd_n, 8'h00);
        hrd(0, K_CMD, s);
        chk("R1 status after reset", s, 8'h00);
        wr16(5'h00, 16'h1234);
        peek(0);
        chk("R1 pointer starts low", eaddr, 16'h1234);
    endtask

    task automatic t_addr_count;
        logic [15:0] v;
        hwr(0, K_CLRPTR, 8'h00);
        wr16(5'h02, 16'hBEEF);
        wr16(5'h03, 16'h0102);
        rd16(5'h02, v);
        chk("R2 ch1 address readback", v, 16'hBEEF);
        rd16(5'h03, v);
        chk("R2 ch1 count readback", v, 16'h0102);
        peek(1);
        chk("R2 ch1 current address", eaddr, 16'hBEEF);
    endtask

    task automatic t_pointer;
        logic [15:0] v;
        hwr(0, K_CLRPTR, 8'h00);
        hwr(0, 5'h04, 8'h55);
        hwr(0, K_CLRPTR, 8'hFF);
        wr16(5'h04, 16'h7766);
        rd16(5'h04, v);
        chk("R3 clear pointer mid pair", v, 16'h7766);
        // shared pointer: low byte of ch0 addr, then ch2 count takes the high byte
        hwr(0, K_CLRPTR, 8'h00);
        hwr(0, 5'h00, 8'h11);
        hwr(0, 5'h05, 8'hAA);
        hwr(0, K_CLRPTR, 8'h00);
        rd16(5'h05, v);
        chk("R2 pointer shared across registers", v, 16'hAA00);
        peek(0);
        chk("R2 ch0 low byte written", eaddr, 16'h1211);
    endtask

    task automatic t_cmd_status;
        logic [7:0] s;
        hwr(0, K_CMD, 8'hA5);
        chk("R4 command write", cmd_n, 8'hA5);
        dreq = 4'b0010;
        hrd(0, K_CMD, s);
        chk("R10 status shows dreq", s, 8'h20);
        dreq = 4'b0000;
    endtask

    task automatic t_mask;
        hwr(0, K_MASK1, 8'h01);
        chk("R5 unmask ch1", mask_n, 4'hD);
        hwr(0, K_MASK1, 8'h07);
        chk("R5 mask ch3 already set", mask_n, 4'hD);
        hwr(0, K_MASK1, 8'h00);
        chk("R5 unmask ch0", mask_n, 4'hC);
        hwr(0, K_CLRMASK, 8'hFF);
        chk("R6 clear all masks", mask_n, 4'h0);
        hwr(0, K_MASKALL, 8'hFA);
        chk("R6 load all masks", mask_n, 4'hA);
        hwr(0, K_MASK1, 8'h06);
        chk("R5 mask ch2", mask_n, 4'hE);
    endtask

    task automatic t_mode;
        hwr(0, K_MODE, 8'h56);
        chk("R7 ch2 mode", mode_n[17:12], 6'h15);
        hwr(0, K_MODE, 8'hD9);
        chk("R7 ch1 mode", mode_n[11:6], 6'h36);
        chk("R7 ch2 kept", mode_n[17:12], 6'h15);
        chk("R7 ch0 untouched", mode_n[5:0], 6'h00);
    endtask

    task automatic t_request;
        logic [7:0] s;
        hwr(0, K_REQ, 8'h07);
        hrd(0, K_CMD, s);
        chk("R11 request ch3 set", s, 8'h80);
        hwr(0, K_REQ, 8'h03);
        hrd(0, K_CMD, s);
        chk("R11 request ch3 cleared", s, 8'h00);
    endtask

    task automatic t_engine;
        logic [15:0] v;
        logic [7:0]  s;
        hwr(0, K_MODE, 8'h44);
        hwr(0, K_CLRPTR, 8'h00);
        wr16(5'h00, 16'h1000);
        wr16(5'h01, 16'h0002);
        peek(0);
        chk("R9 not last at count 2", elast, 1'b0);
        do_step(0);
        do_step(0);
        peek(0);
        chk("R8 address after two steps", eaddr, 16'h1002);
        chk("R9 last at count 0", elast, 1'b1);
        rd16(5'h01, v);
        chk("R8 count after two steps", v, 16'h0000);
        hrd(0, K_CMD, s);
        chk("R9 no tc before third step", s, 8'h00);
        do_step(0);
        peek(0);
        chk("R9 address after wrap", eaddr, 16'h1003);
        rd16(5'h01, v);
        chk("R9 count wraps", v, 16'hFFFF);
        hrd(0, K_CMD, s);
        chk("R9 tc flag ch0", s, 8'h01);
        hrd(0, K_CMD, s);
        chk("R10 status cleared by read", s, 8'h00);
        // decrementing channel, count 0 terminal on first step
        hwr(0, K_MODE, 8'h65);
        wr16(5'h02, 16'h0010);
        wr16(5'h03, 16'h0000);
        do_step(1);
        peek(1);
        chk("R8 decrement address", eaddr, 16'h000F);
        hrd(0, K_CMD, s);
        chk("R9 tc flag ch1", s, 8'h02);
    endtask

    task automatic t_autoinit;
        logic [15:0] v;
        hwr(0, K_MODE, 8'h56);
        hwr(0, K_CLRPTR, 8'h00);
        wr16(5'h04, 16'h2000);
        wr16(5'h05, 16'h0001);
        do_step(2);
        peek(2);
        chk("R8 autoinit channel steps", eaddr, 16'h2001);
        do_step(2);
        peek(2);
        chk("R9 autoinit reload address", eaddr, 16'h2000);
        rd16(5'h05, v);
        chk("R9 autoinit reload count", v, 16'h0001);
    endtask

    task automatic t_mclr;
        logic [7:0] s;
        hwr(0, K_CMD, 8'h3C);
        hwr(0, K_REQ, 8'h04);
        hwr(0, K_CLRMASK, 8'h00);
        hwr(0, 5'h06, 8'h99);
        hwr(0, K_MCLR, 8'h00);
        chk("R4 master clear masks", mask_n, 4'hF);
        chk("R4 master clear command", cmd_n, 8'h00);
        hrd(0, K_CMD, s);
        chk("R4 master clear status and request", s, 8'h00);
        hrd(0, K_MCLR, s);
        chk("R4 temporary reads zero", s, 8'h00);
        hrd(0, 5'h04, s);
        chk("R4 master clear resets pointer", s, 8'h00);
        hrd(0, 5'h04, s);
        chk("R4 pointer then high byte", s, 8'h20);
    endtask

    task automatic t_stride;
        logic [7:0] s;
        hwr(1, 5'h04, 8'h3C);
        hwr(1, 5'h04, 8'h5A);
        hrd(1, 5'h04, s);
        chk("R12 stride2 ch1 low", s, 8'h3C);
        hrd(1, 5'h04, s);
        chk("R12 stride2 ch1 high", s, 8'h5A);
        hwr(1, 5'h10, 8'h81);
        chk("R12 stride2 command", cmd_w, 8'h81);
        hwr(1, 5'h1C, 8'h00);
        chk("R12 stride2 clear masks", mask_w, 4'h0);
        hwr(1, 5'h1B, 8'h00);
        chk("R12 odd offset ignored", mask_w, 4'h0);
        chk("R12 odd offset keeps command", cmd_w, 8'h81);
        hwr(1, 5'h1A, 8'h00);
        chk("R12 stride2 master clear", mask_w, 4'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_count();
        t_pointer();
        t_cmd_status();
        t_mask();
        t_mode();
        t_request();
        t_engine();
        t_autoinit();
        t_mclr();
        t_stride();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule